// File: doc/BRIEF.md
# Burst Sample Fetch Engine

This block is the read side of a streaming filter datapath. It is a bus master that pulls 32-bit words from memory and feeds 16-bit samples into the filter's input FIFO. Software loads a start address and a word count through `cfg_load`, then raises `run`. The engine issues fixed-size incrementing read bursts on an address/data read channel in the style of AXI, one burst at a time. After each request is accepted it moves its address pointer on and lowers its remaining count. It splits every returned beat into two samples and presents them to the FIFO on a two-lane push port.

A burst is requested only when the FIFO reports enough free entries to take the whole burst. Because of this, the read data channel never needs to push back. The remaining count is signed, so a count that is zero or negative, whether loaded that way or reached after the final burst, stops further requests and raises `done` once the bus is quiet.

Top module: `burst_fetch_dma`

## Requirements
- R1: A read request (`arvalid` rising) is raised only if, in the cycle before, `run` was 1, the remaining count was greater than zero as a signed value, `fifo_free` was at least 32, and no push was pending. With `fifo_free` = 31, no request is made.
- R2: Every request carries `arlen` = 15 (16 beats), `arsize` = 2 (4 bytes), `arburst` = 2'b01 (incrementing), `arlock` = 0 and `arid` = 1.
- R3: The first request after a load uses the loaded `start_addr`. Each accepted request advances the address by 0x40 and lowers the remaining count by 16.
- R4: The cycle after a beat is accepted, `push_en` = 2'b11. `push_data[15:0]` (lane 0, written to the FIFO first) holds `rdata[15:0]` and `push_data[31:16]` holds `rdata[31:16]`. In any other cycle `push_en` = 2'b00.
- R5: Once a request is accepted, no new request is raised until the beat with `rlast` has been accepted.
- R6: While `arvalid` is 1 and `arready` is 0, `arvalid` stays 1 and `araddr` stays unchanged.
- R7: `rready` is 1 in every cycle after the first clock edge out of reset.
- R8: `done` is 1 exactly when the remaining count is zero or negative and no request is pending or outstanding.
- R9: Reset leaves `arvalid` = 0, `push_en` = 0, `rready` = 0 and the remaining count at 0, so `done` = 1 once reset is released.
- R10: `cfg_load` is ignored while a request is pending or outstanding.
- R11: A count that is not a multiple of 16 (for example 20) still issues whole bursts, then goes negative and stops.
- R12: With `run` = 0 no request is raised. Dropping `run` during a burst lets that burst finish and blocks the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enable for issuing bursts |
| cfg_load | input | 1 | Load start address and count (idle only) |
| start_addr | input | 32 | Byte address of the first word |
| start_len | input | 32 | Word count, signed |
| fifo_free | input | 6 | Free entries in the sample FIFO |
| arvalid | output | 1 | Read request valid |
| arready | input | 1 | Read request accepted |
| araddr | output | 32 | Burst start address |
| arlen | output | 8 | Beats minus one |
| arsize | output | 3 | Log2 of bytes per beat |
| arburst | output | 2 | Burst type |
| arlock | output | 1 | Locked access flag |
| arid | output | 4 | Transaction ID |
| rvalid | input | 1 | Read beat valid |
| rdata | input | 32 | Read beat data |
| rlast | input | 1 | Last beat of burst |
| rready | output | 1 | Read beat accept |
| push_en | output | 2 | Per-lane FIFO write enable |
| push_data | output | 32 | Lane 0 in [15:0], lane 1 in [31:16] |
| done | output | 1 | Count exhausted and bus quiet |

## Verification
A request rises one clock after the cycle whose `run`, count and `fifo_free` allow it. Both lanes of a beat appear on the push port one clock after that beat's handshake. `done` and the loaded count follow one clock after the edge that changed them. The bench drives every input at the falling edge and samples at the next falling edge, so each result it reads has had exactly the register stages that produce it. Counts of bursts and pushes are compared only after a settling window longer than the slowest run, and lane contents are checked on every push against the address stream the bench predicts from the loaded start address.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } fetch_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/burst_issue_ctrl.sv
module burst_issue_ctrl
   import dma_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 32,
   parameter int FREE_W  = 6,
   parameter int BEATS   = 16,
   parameter int STEP    = 64,
   parameter int RESERVE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  start_len,
   input  logic [FREE_W-1:0] fifo_free,
   input  logic              push_busy,
   input  logic              arready,
   input  logic              beat_fire,
   input  logic              rlast,
   output logic              arvalid,
   output logic [ADDR_W-1:0] araddr,
   output logic              done
);
   fetch_state_e      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic              have_work;
   logic              room_ok;
   logic              issue_ok;

   // remaining count is signed: zero or below means nothing left
   assign have_work = $signed(left_q) > 0;
   assign room_ok   = fifo_free >= FREE_W'(RESERVE);
   assign issue_ok  = run && have_work && room_ok && !push_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (cfg_load) begin
                  addr_q <= start_addr;
                  left_q <= start_len;
               end else if (issue_ok) begin
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (arready) begin
                  addr_q  <= addr_q + ADDR_W'(STEP);
                  left_q  <= left_q - LEN_W'(BEATS);
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (beat_fire && rlast) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign arvalid = (state_q == ST_REQ);
   assign araddr  = addr_q;
   assign done    = (state_q == ST_IDLE) && !have_work;
endmodule

// File: rtl/beat_unpack.sv
module beat_unpack #(
   parameter int SAMPLE_W = 16,
   parameter int LANES    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      beat_fire,
   input  logic [LANES*SAMPLE_W-1:0] beat_data,
   output logic [LANES-1:0]          push_en,
   output logic [LANES*SAMPLE_W-1:0] push_data
);
   // lane k carries slice k of the beat; lane 0 (low half) is written first
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            push_en[k]                       <= 1'b0;
            push_data[k*SAMPLE_W +: SAMPLE_W] <= '0;
         end else begin
            push_en[k] <= beat_fire;
            if (beat_fire)
               push_data[k*SAMPLE_W +: SAMPLE_W] <= beat_data[k*SAMPLE_W +: SAMPLE_W];
         end
      end
   end
endmodule

// File: rtl/burst_fetch_dma.sv
module burst_fetch_dma
   import dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 32,
   parameter int DATA_W     = 32,
   parameter int SAMPLE_W   = 16,
   parameter int BEATS      = 16,
   parameter int FIFO_DEPTH = 32,
   parameter int ID_W       = 4,
   parameter int ID_VAL     = 1,
   localparam int LANES     = DATA_W / SAMPLE_W,
   localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                cfg_load,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic [LEN_W-1:0]    start_len,
   input  logic [FREE_W-1:0]   fifo_free,
   output logic                arvalid,
   input  logic                arready,
   output logic [ADDR_W-1:0]   araddr,
   output logic [7:0]          arlen,
   output logic [2:0]          arsize,
   output logic [1:0]          arburst,
   output logic                arlock,
   output logic [ID_W-1:0]     arid,
   input  logic                rvalid,
   input  logic [DATA_W-1:0]   rdata,
   input  logic                rlast,
   output logic                rready,
   output logic [LANES-1:0]    push_en,
   output logic [DATA_W-1:0]   push_data,
   output logic                done
);
   localparam int RESERVE   = BEATS * LANES;
   localparam int STEP      = BEATS * (DATA_W / 8);
   localparam int SIZE_CODE = $clog2(DATA_W / 8);

   if (DATA_W % SAMPLE_W != 0) begin : g_bad_lanes
      $error("DATA_W must be a multiple of SAMPLE_W");
   end
   if (BEATS < 1 || BEATS > 256) begin : g_bad_beats
      $error("BEATS must lie in 1..256");
   end
   if (RESERVE > FIFO_DEPTH) begin : g_bad_depth
      $error("FIFO_DEPTH cannot hold a whole burst");
   end

   logic beat_fire;
   logic push_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) rready <= 1'b0;
      else        rready <= 1'b1;
   end

   assign beat_fire = rvalid && rready;
   assign push_busy = |push_en;

   assign arlen   = 8'(BEATS - 1);
   assign arsize  = 3'(SIZE_CODE);
   assign arburst = BURST_INCR;
   assign arlock  = 1'b0;
   assign arid    = ID_W'(ID_VAL);

   burst_issue_ctrl #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FREE_W(FREE_W),
      .BEATS(BEATS), .STEP(STEP), .RESERVE(RESERVE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .run(run), .cfg_load(cfg_load),
      .start_addr(start_addr), .start_len(start_len), .fifo_free(fifo_free),
      .push_busy(push_busy), .arready(arready), .beat_fire(beat_fire),
      .rlast(rlast), .arvalid(arvalid), .araddr(araddr), .done(done)
   );

   beat_unpack #(
      .SAMPLE_W(SAMPLE_W), .LANES(LANES)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .beat_data(rdata),
      .push_en(push_en), .push_data(push_data)
   );
endmodule

// File: rtl/burst_fetch_dma_chk.sv
module burst_fetch_dma_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SAMPLE_W = 16,
   parameter int LANES    = 2,
   parameter int FREE_W   = 6,
   parameter int RESERVE  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic [FREE_W-1:0] fifo_free,
   input logic              arvalid,
   input logic              arready,
   input logic [ADDR_W-1:0] araddr,
   input logic              rvalid,
   input logic              rready,
   input logic              rlast,
   input logic [DATA_W-1:0] rdata,
   input logic [LANES-1:0]  push_en,
   input logic [DATA_W-1:0] push_data,
   input logic              done
);
   logic outst;

   always_ff @(posedge clk) begin
      if (!rst_n)                         outst <= 1'b0;
      else if (arvalid && arready)        outst <= 1'b1;
      else if (rvalid && rready && rlast) outst <= 1'b0;
   end

   AST_ISSUE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arvalid) |-> $past(run) && ($past(fifo_free) >= FREE_W'(RESERVE))); // R1
   AST_SINGLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !arvalid); // R5
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid && $stable(araddr)); // R6
   AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && rready |=> (push_en == '1) &&
         (push_data[SAMPLE_W-1:0] == $past(rdata[SAMPLE_W-1:0]))); // R4
   AST_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rvalid && rready) |=> push_en == '0); // R4
   AST_RREADY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> rready); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !arvalid && !outst); // R8
endmodule

bind burst_fetch_dma burst_fetch_dma_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W),
   .LANES(LANES), .FREE_W(FREE_W), .RESERVE(RESERVE)
) u_chk (.*);

// File: tb/sim_burst_fetch_dma.sv
`timescale 1ns/1ps
module sim_burst_fetch_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] start_addr = '0;
   logic [31:0] start_len = '0;
   logic [5:0]  fifo_free = 6'd32;
   logic        arvalid, arready;
   logic [31:0] araddr;
   logic [7:0]  arlen;
   logic [2:0]  arsize;
   logic [1:0]  arburst;
   logic        arlock;
   logic [3:0]  arid;
   logic        rvalid, rlast, rready;
   logic [31:0] rdata;
   logic [1:0]  push_en;
   logic [31:0] push_data;
   logic        done;

   int total = 0;
   int bad = 0;
   int bursts = 0;
   int pushes = 0;
   int ar_delay = 0;
   logic [31:0] exp_ar = '0;
   logic [15:0] exp_lo = '0;

   always #4 clk = ~clk;

   burst_fetch_dma u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .cfg_load(cfg_load),
      .start_addr(start_addr), .start_len(start_len), .fifo_free(fifo_free),
      .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
      .arsize(arsize), .arburst(arburst), .arlock(arlock), .arid(arid),
      .rvalid(rvalid), .rdata(rdata), .rlast(rlast), .rready(rready),
      .push_en(push_en), .push_data(push_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // memory model: beat at byte address A returns {A[15:0]^5A5A, A[15:0]}
   initial begin
      arready = 1'b0; rvalid = 1'b0; rlast = 1'b0; rdata = '0;
      forever begin
         @(negedge clk);
         if (rst_n && arvalid) begin
            logic [31:0] a;
            a = araddr;
            for (int d = 0; d < ar_delay; d++) begin
               @(negedge clk);
               chk(arvalid === 1'b1 && araddr === a, "R6", "request held", araddr, a);
            end
            chk(araddr == exp_ar, "R3", "burst address", araddr, exp_ar);
            chk(arlen == 8'd15 && arsize == 3'd2 && arburst == 2'b01 &&
                arlock == 1'b0 && arid == 4'd1, "R2", "burst fields",
                {arlen, arsize, arburst, arlock, arid}, {8'd15, 3'd2, 2'b01, 1'b0, 4'd1});
            exp_ar = exp_ar + 32'h40;
            bursts++;
            arready = 1'b1;
            @(negedge clk);
            arready = 1'b0;
            for (int b = 0; b < 16; b++) begin
               logic [15:0] lo;
               lo = a[15:0] + 16'(4 * b);
               rvalid = 1'b1;
               rdata  = {lo ^ 16'h5A5A, lo};
               rlast  = (b == 15);
               @(negedge clk);
               chk(!arvalid, "R5", "no request while outstanding", arvalid, 0);
            end
            rvalid = 1'b0; rlast = 1'b0;
         end
      end
   end

   // push monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && push_en != 2'b00) begin
            chk(push_en == 2'b11, "R4", "both lanes", push_en, 2'b11);
            chk(push_data == {exp_lo ^ 16'h5A5A, exp_lo}, "R4", "lane order",
                push_data, {exp_lo ^ 16'h5A5A, exp_lo});
            exp_lo = exp_lo + 16'd4;
            pushes++;
         end
      end
   end

   task automatic load(input logic [31:0] a, input logic [31:0] n);
      @(negedge clk);
      cfg_load = 1'b1; start_addr = a; start_len = n;
      @(negedge clk);
      cfg_load = 1'b0;
      exp_ar = a; exp_lo = a[15:0]; bursts = 0; pushes = 0;
   endtask

   localparam int NV = 6;
   localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2040, 32'hFFC0, 32'h3000, 32'h4000, 32'h5000};
   localparam logic [31:0] V_LEN  [NV] = '{32'd32, 32'd16, 32'd20, 32'd0, 32'hFFFF_FFFB, 32'd48};
   localparam int          V_DLY  [NV] = '{0, 3, 1, 0, 0, 2};
   localparam int          V_NB   [NV] = '{2, 1, 2, 0, 0, 3};

   bit finished = 1'b0;

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(arvalid == 1'b0 && push_en == 2'b00 && rready == 1'b0, "R9", "in reset",
          {arvalid, push_en, rready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rready == 1'b1, "R7", "rready after reset", rready, 1);
      chk(done == 1'b1, "R9", "done after reset", done, 1);

      // table of vectors
      for (int v = 0; v < NV; v++) begin
         run = 1'b0;
         ar_delay = V_DLY[v];
         load(V_ADDR[v], V_LEN[v]);
         chk(done == ($signed(V_LEN[v]) <= 0), "R8", "done after load", done,
             $signed(V_LEN[v]) <= 0);
         run = 1'b1;
         repeat (120) @(negedge clk);
         chk(bursts == V_NB[v], "R11", "burst count", bursts, V_NB[v]);
         chk(pushes == 16 * V_NB[v], "R4", "push count", pushes, 16 * V_NB[v]);
         chk(done == 1'b1, "R8", "done at end", done, 1);
      end
      ar_delay = 0;

      // R1: FIFO space gate
      run = 1'b0;
      load(32'h6000, 32'd16);
      fifo_free = 6'd31;
      run = 1'b1;
      repeat (30) @(negedge clk);
      chk(bursts == 0 && arvalid == 1'b0, "R1", "gated by free space", bursts, 0);
      fifo_free = 6'd32;
      repeat (60) @(negedge clk);
      chk(bursts == 1, "R1", "issued once space is free", bursts, 1);

      // R12: run control
      run = 1'b0;
      load(32'h7000, 32'd48);
      repeat (30) @(negedge clk);
      chk(bursts == 0, "R12", "idle while run low", bursts, 0);
      run = 1'b1;
      wait (bursts == 1);
      @(negedge clk);
      run = 1'b0;
      repeat (80) @(negedge clk);
      chk(bursts == 1, "R12", "current burst only", bursts, 1);
      chk(pushes == 16, "R12", "current burst completed", pushes, 16);
      chk(done == 1'b0, "R8", "count left so not done", done, 0);
      run = 1'b1;
      repeat (120) @(negedge clk);
      chk(bursts == 3 && done == 1'b1, "R12", "resumed to end", bursts, 3);

      // R10: load during a burst is ignored
      run = 1'b0;
      load(32'h8000, 32'd16);
      run = 1'b1;
      wait (bursts == 1);
      @(negedge clk);
      cfg_load = 1'b1; start_addr = 32'h9000; start_len = 32'd64;
      @(negedge clk);
      cfg_load = 1'b0;
      repeat (80) @(negedge clk);
      chk(bursts == 1, "R10", "no extra bursts", bursts, 1);
      chk(done == 1'b1, "R10", "count unchanged by load", done, 1);

      // R9: reset clears the count
      run = 1'b0;
      load(32'hA000, 32'd16);
      chk(done == 1'b0, "R8", "pending count", done, 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b1 && arvalid == 1'b0, "R9", "count cleared by reset", done, 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule